// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a two-port synchronous RAM, with ports A and B, plus a mailbox interrupt scheme. Each port has its own active-low chip select, output enable and write enable, along with an address, write data and registered read data. Either port can read or write any word at any time.

The two highest addresses act as mailboxes. Address `2^AW-2` belongs to port A and address `2^AW-1` belongs to port B. When one port writes the other port's mailbox, the other port's active-low interrupt output goes low. The flagged port acknowledges by accessing its own mailbox, which clears its interrupt. The message word stays in ordinary storage, so the receiver reads the payload in the same access that clears the interrupt.

A mode input, `irq_en`, switches the interrupt function off. While it is off, the two mailbox words are plain memory and no interrupt is raised.

Top module: `mbx_dpram`

## Requirements
- R1: After reset, `a_irq_n` and `b_irq_n` are both high (deasserted).
- R2: A port writes when its `cs_n`=0 and `we_n`=0, storing `wdata` at `addr` on the clock edge. A port reads when its `cs_n`=0 and `we_n`=1, and `rdata` shows the stored word after that edge. The two ports work independently in the same cycle.
- R3: With `irq_en`=1, a port B write to address `2^AW-2` drives `a_irq_n` low after that edge.
- R4: Port A clears its interrupt by an access to address `2^AW-2` with `a_cs_n`=0 and `a_oe_n`=0. The level of `a_we_n` does not matter for this clear. `a_irq_n` is high after that edge.
- R5: With `irq_en`=1, a port A write to address `2^AW-1` drives `b_irq_n` low after that edge.
- R6: Port B clears its interrupt only by a read of address `2^AW-1` with `b_cs_n`=0, `b_oe_n`=0 and `b_we_n`=1. A port B write to that address, or a read with `b_oe_n`=1, leaves `b_irq_n` low.
- R7: The 18-bit mailbox words are stored and read back like any other location, including during the access that clears an interrupt.
- R8: With `irq_en`=0, no interrupt is raised and the mailbox words act as plain memory. Dropping `irq_en` to 0 deasserts any pending interrupt on the next edge, and the interrupt is not restored when `irq_en` returns to 1.
- R9: If a mailbox is written in the same cycle that its owner clears it, the set wins and the interrupt stays asserted.
- R10: A port with `cs_n`=1 neither sets nor clears any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | 1 = mailbox interrupts on |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, registered |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, registered |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The bench builds the block with `AW`=4 and `DW`=18. With 16 words, the mailboxes sit at addresses 14 and 15, next to ordinary words the bench also uses. This makes it easy to tell mailbox side effects apart from plain storage. The data width stays at 18 bits, so the payload patterns use every bit of the word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // The port writes on this edge.
  function automatic logic port_writes(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

  // The port reads on this edge.
  function automatic logic port_reads(input logic cs_n, input logic we_n);
    return !cs_n && we_n;
  endfunction

  // The port is selected with its output enabled (any write-enable level).
  function automatic logic port_looks(input logic cs_n, input logic oe_n);
    return !cs_n && !oe_n;
  endfunction
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          b_wr_eff;

  // Same-address collision: port A data is kept.
  assign b_wr_eff = b_wr && !(a_wr && (a_addr == b_addr));

  always_ff @(posedge clk) begin
    if (a_wr)     mem[a_addr] <= a_wdata;
    if (b_wr_eff) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (!en)     irq_q <= 1'b0;
    else if (set_evt) irq_q <= 1'b1;
    else if (clr_evt) irq_q <= 1'b0;
  end

  assign irq_n = !irq_q;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    en && set_evt |=> !irq_n);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr_evt && !set_evt |=> irq_n);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> irq_n);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en && !set_evt && !clr_evt |=> $stable(irq_n));
endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram
  import mbx_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_en,
  input  logic          a_cs_n,
  input  logic          a_oe_n,
  input  logic          a_we_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq_n,
  input  logic          b_cs_n,
  input  logic          b_oe_n,
  input  logic          b_we_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq_n
);
  localparam logic [AW-1:0] MBOX_A = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] MBOX_B = {AW{1'b1}};

  // Named internal events.
  logic a_wr, a_rd, b_wr, b_rd;
  logic set_a, clr_a, set_b, clr_b;

  assign a_wr = port_writes(a_cs_n, a_we_n);
  assign a_rd = port_reads(a_cs_n, a_we_n);
  assign b_wr = port_writes(b_cs_n, b_we_n);
  assign b_rd = port_reads(b_cs_n, b_we_n);

  assign set_a = b_wr && (b_addr == MBOX_A);
  assign clr_a = port_looks(a_cs_n, a_oe_n) && (a_addr == MBOX_A);
  assign set_b = a_wr && (a_addr == MBOX_B);
  assign clr_b = b_rd && !b_oe_n && (b_addr == MBOX_B);

  mbx_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  mbx_flag u_flag_a (
    .clk(clk), .rst_n(rst_n), .en(irq_en),
    .set_evt(set_a), .clr_evt(clr_a), .irq_n(a_irq_n)
  );

  mbx_flag u_flag_b (
    .clk(clk), .rst_n(rst_n), .en(irq_en),
    .set_evt(set_b), .clr_evt(clr_b), .irq_n(b_irq_n)
  );

  // R10: a deselected port never produces a flag event.
  a_r10_deselect_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_cs_n |-> !(set_b || clr_a));
  a_r10_deselect_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_cs_n |-> !(set_a || clr_b));
endmodule

// File: tb/mbx_dpram_bench.sv
module mbx_dpram_bench;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam logic [AW-1:0] MA = 4'd14;
  localparam logic [AW-1:0] MB = 4'd15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_en = 1'b1;
  logic a_cs_n = 1'b1, a_oe_n = 1'b1, a_we_n = 1'b1;
  logic b_cs_n = 1'b1, b_oe_n = 1'b1, b_we_n = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq_n, b_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = !clk;

  mbx_dpram #(.AW(AW), .DW(DW)) u_mbx_dpram (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .a_cs_n(a_cs_n), .a_oe_n(a_oe_n), .a_we_n(a_we_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_cs_n(b_cs_n), .b_oe_n(b_oe_n), .b_we_n(b_we_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drv_a(input logic cs_n, input logic oe_n, input logic we_n,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_cs_n = cs_n; a_oe_n = oe_n; a_we_n = we_n; a_addr = ad; a_wdata = d;
  endtask

  task automatic drv_b(input logic cs_n, input logic oe_n, input logic we_n,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_cs_n = cs_n; b_oe_n = oe_n; b_we_n = we_n; b_addr = ad; b_wdata = d;
  endtask

  // Applies the driven inputs over one rising edge, then idles both ports.
  task automatic tick();
    @(negedge clk);
    drv_a(1, 1, 1, '0, '0);
    drv_b(1, 1, 1, '0, '0);
  endtask

  task automatic t_reset();
    chk("R1 a_irq_n", a_irq_n, 1);
    chk("R1 b_irq_n", b_irq_n, 1);
  endtask

  task automatic t_ram();
    drv_a(0, 1, 0, 4'd3, 18'h2A5A5);
    drv_b(0, 1, 0, 4'd5, 18'h15A5A);
    tick();
    drv_a(0, 0, 1, 4'd5, '0);
    drv_b(0, 0, 1, 4'd3, '0);
    tick();
    chk("R2 a reads b word", a_rdata, 18'h15A5A);
    chk("R2 b reads a word", b_rdata, 18'h2A5A5);
    chk("R2 no irq a", a_irq_n, 1);
    chk("R2 no irq b", b_irq_n, 1);
  endtask

  task automatic t_mbox_a();
    drv_b(0, 1, 0, MA, 18'h3C0FF);
    tick();
    chk("R3 a_irq_n set", a_irq_n, 0);
    chk("R3 b_irq_n untouched", b_irq_n, 1);
    drv_a(0, 0, 1, MA, '0);
    tick();
    chk("R4 clear by read", a_irq_n, 1);
    chk("R7 message a", a_rdata, 18'h3C0FF);
    drv_b(0, 1, 0, MA, 18'h00ABC);
    tick();
    chk("R3 set again", a_irq_n, 0);
    drv_a(0, 0, 0, MA, 18'h00001);
    tick();
    chk("R4 clear with we_n low", a_irq_n, 1);
    drv_a(0, 0, 1, MA, '0);
    tick();
    chk("R7 mailbox plain store", a_rdata, 18'h00001);
  endtask

  task automatic t_mbox_b();
    drv_a(0, 1, 0, MB, 18'h12345);
    tick();
    chk("R5 b_irq_n set", b_irq_n, 0);
    chk("R5 a_irq_n untouched", a_irq_n, 1);
    drv_b(0, 0, 0, MB, 18'h00777);
    tick();
    chk("R6 write keeps flag", b_irq_n, 0);
    drv_b(0, 1, 1, MB, '0);
    tick();
    chk("R6 oe high keeps flag", b_irq_n, 0);
    drv_b(0, 0, 1, MB, '0);
    tick();
    chk("R6 read clears", b_irq_n, 1);
    chk("R7 message b", b_rdata, 18'h00777);
  endtask

  task automatic t_deselect();
    drv_b(1, 1, 0, MA, 18'h11111);
    tick();
    chk("R10 deselected b no set", a_irq_n, 1);
    drv_b(0, 1, 0, MA, 18'h22222);
    tick();
    drv_a(1, 0, 1, MA, '0);
    tick();
    chk("R10 deselected a no clear", a_irq_n, 0);
    drv_a(0, 0, 1, MA, '0);
    tick();
    chk("R10 cleanup", a_irq_n, 1);
  endtask

  task automatic t_prio();
    drv_b(0, 1, 0, MA, 18'h00AAA);
    drv_a(0, 0, 1, MA, '0);
    tick();
    chk("R9 a set wins", a_irq_n, 0);
    drv_a(0, 0, 1, MA, '0);
    tick();
    drv_a(0, 1, 0, MB, 18'h00BBB);
    drv_b(0, 0, 1, MB, '0);
    tick();
    chk("R9 b set wins", b_irq_n, 0);
    drv_b(0, 0, 1, MB, '0);
    tick();
    chk("R9 cleanup", {a_irq_n, b_irq_n}, 2'b11);
  endtask

  task automatic t_disable();
    irq_en = 1'b0;
    drv_b(0, 1, 0, MA, 18'h0F0F0);
    drv_a(0, 1, 0, MB, 18'h30303);
    tick();
    chk("R8 no a irq", a_irq_n, 1);
    chk("R8 no b irq", b_irq_n, 1);
    drv_a(0, 0, 1, MA, '0);
    drv_b(0, 0, 1, MB, '0);
    tick();
    chk("R8 plain mem a", a_rdata, 18'h0F0F0);
    chk("R8 plain mem b", b_rdata, 18'h30303);
    irq_en = 1'b1;
    drv_b(0, 1, 0, MA, 18'h00005);
    tick();
    chk("R8 pending before drop", a_irq_n, 0);
    irq_en = 1'b0;
    tick();
    chk("R8 drop clears", a_irq_n, 1);
    irq_en = 1'b1;
    tick();
    chk("R8 not restored", a_irq_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram();
    t_mbox_a();
    t_mbox_b();
    t_deselect();
    t_prio();
    t_disable();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule